// File: doc/BRIEF.md
# Non-Destructive RAM Size Probe

This engine finds how much memory is really fitted behind a word-addressed port whose window may be larger than the fitted part. Parts that are too small alias: their upper address lines are not decoded, so a write above the fitted size lands on a lower word. The engine writes a signature (the bitwise inverse of the word offset) at every power-of-two offset from the top of the window down to 1. It then zeroes the base word and reads the offsets back in ascending order. The first offset that does not return its own signature marks the fitted size.

Every word the engine overwrites is first copied into a small register file. The copies are written back so that, whatever the outcome, memory holds exactly what it held before the probe. The engine talks to memory through a simple port: a request with a write enable, an address and write data, and for reads a later read-valid strobe carrying read data. It issues one request at a time.

The controller runs through these states. IDLE: wait for start. SAVE_RD / SAVE_WT: read and keep the word at base+offset. SIG_WR: write the inverse of the offset, then halve the offset or move on at offset 1. BSAVE_RD / BSAVE_WT: keep the base word. BZERO_WR: zero the base. BCHK_RD / BCHK_WT: read the base back. A non-zero value takes the error transition to BFIX_WR with size 0; zero takes the check transition to CHK_RD at offset 1. CHK_RD / CHK_WT: read an offset. A match goes to FIX_WR, which writes the saved word back and doubles the offset. A mismatch latches the size and goes to BFIX_WR. After FIX_WR at the top offset, the full-size transition goes to BFIX_WR. BFIX_WR: put the base word back, then go to TAIL_WR if restores remain, otherwise to DONE. TAIL_WR: write back the saved words of the remaining offsets in ascending order. DONE: report, and accept a new start.

Top module: `ram_size_probe`

## Requirements
- R1: After start, the first request reads base+MAX_WORDS, and the next is a write of `~offset` (zero-extended offset, inverted, DATA_W bits) to the same address. The offsets run MAX_WORDS, MAX_WORDS/2 … 1, with one read then one write at each.
- R2: After the signature writes, the engine reads the base word, writes 0 to it, and reads it again: request numbers 2·(log2 MAX_WORDS+1), +1 and +2, counted from 0.
- R3: If the base reads back non-zero, size_bytes is 0 and all touched words are restored.
- R4: The check phase reads offsets 1, 2, 4 … in ascending order. The first offset whose data is not `~offset` gives size_bytes = offset × DATA_W/8. size_bytes is always 0 or a power of two.
- R5: If every offset through MAX_WORDS matches, size_bytes = MAX_WORDS × DATA_W/8.
- R6: After a read request, no further request is issued until mem_rvalid arrives. Any read latency of one cycle or more is accepted.
- R7: When done rises, every memory word, including the base and aliased words, holds its value from before start.
- R8: While done is high, mem_req stays low and size_bytes stays stable. done drops when a new probe starts.
- R9: During and right after reset, done, mem_req and size_bytes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a probe (taken in IDLE or DONE) |
| mem_req | output | 1 | Memory request strobe |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Word address |
| mem_wdata | output | DATA_W | Write data |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | DATA_W | Read data |
| done | output | 1 | Probe finished, size valid |
| size_bytes | output | SIZE_W | Detected size in bytes |

## Verification
The bench builds the engine with MAX_WORDS = 64, ADDR_W = 8 and 32-bit words, so each probe has only seven offsets and a run takes a few dozen requests. This small window makes every outcome cheap to reach:
- no aliasing at all;
- aliasing at the top offset only;
- aliasing at mid-window offsets;
- the single-word case, where every address aliases the base;
- a base word stuck high, which takes the error path.

Read latencies of one to three cycles are mixed across these runs.

// File: rtl/ram_probe_pkg.sv
package ram_probe_pkg;
    typedef enum logic [3:0] {
        S_IDLE,
        S_SAVE_RD,
        S_SAVE_WT,
        S_SIG_WR,
        S_BSAVE_RD,
        S_BSAVE_WT,
        S_BZERO_WR,
        S_BCHK_RD,
        S_BCHK_WT,
        S_CHK_RD,
        S_CHK_WT,
        S_FIX_WR,
        S_BFIX_WR,
        S_TAIL_WR,
        S_DONE
    } probe_state_t;
endpackage

// File: rtl/ram_probe_level.sv
module ram_probe_level #(
    parameter int LEVELS = 10,
    parameter int LVL_W  = 4,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_top,
    input  logic              inc,
    input  logic              dec,
    output logic [LVL_W-1:0]  level,
    output logic [ADDR_W-1:0] offset,
    output logic              at_top,
    output logic              at_zero
);
    always_ff @(posedge clk) begin
        if (!rst_n)        level <= '0;
        else if (load_top) level <= LVL_W'(LEVELS);
        else if (inc)      level <= level + 1'b1;
        else if (dec)      level <= level - 1'b1;
    end

    assign offset  = ADDR_W'(1) << level;
    assign at_top  = (level == LVL_W'(LEVELS));
    assign at_zero = (level == '0);

    // R1: offsets stay inside the probed window
    assert_level_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LVL_W'(LEVELS));
endmodule

// File: rtl/ram_probe_stack.sv
module ram_probe_stack #(
    parameter int DATA_W = 32,
    parameter int SLOTS  = 12,
    parameter int LVL_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [LVL_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [LVL_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic [DATA_W-1:0] base_data
);
    logic [DATA_W-1:0] slot [SLOTS];

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n)
                slot[g] <= '0;
            else if (wr_en && wr_idx == LVL_W'(g))
                slot[g] <= wr_data;
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < SLOTS; k++)
            if (rd_idx == LVL_W'(k)) rd_data = slot[k];
    end

    assign base_data = slot[SLOTS-1];

    // R7: a saved word always lands in an existing slot
    assert_slot_index_R7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> wr_idx <= LVL_W'(SLOTS-1));
endmodule

// File: rtl/ram_size_probe.sv
module ram_size_probe
    import ram_probe_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int ADDR_W    = 16,
    parameter int MAX_WORDS = 1024,
    parameter int BASE_WORD = 0,
    localparam int SIZE_W   = $clog2(MAX_WORDS * (DATA_W / 8)) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic              mem_rvalid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              done,
    output logic [SIZE_W-1:0] size_bytes
);
    localparam int LEVELS    = $clog2(MAX_WORDS);
    localparam int SLOTS     = LEVELS + 2;
    localparam int LVL_W     = $clog2(SLOTS);
    localparam int BYTE_SH   = $clog2(DATA_W / 8);
    localparam logic [LVL_W-1:0]  BASE_SLOT = LVL_W'(SLOTS - 1);
    localparam logic [ADDR_W-1:0] BASE_ADDR = ADDR_W'(BASE_WORD);
    localparam logic [ADDR_W-1:0] TOP_ADDR  = ADDR_W'(BASE_WORD + MAX_WORDS);
    localparam logic [SIZE_W-1:0] FULL_SIZE = SIZE_W'(MAX_WORDS) << BYTE_SH;

    probe_state_t state_q, state_d;
    logic [SIZE_W-1:0] size_q;
    logic              tail_q;
    logic              set_size, tail_d;
    logic [SIZE_W-1:0] size_d;
    logic              lvl_load, lvl_inc, lvl_dec;
    logic [LVL_W-1:0]  level;
    logic [ADDR_W-1:0] offset;
    logic              at_top, at_zero;
    logic              save_en;
    logic [LVL_W-1:0]  save_idx;
    logic [DATA_W-1:0] saved_word, saved_base;
    logic [DATA_W-1:0] signature;

    assign signature = ~DATA_W'(offset);

    ram_probe_level #(.LEVELS(LEVELS), .LVL_W(LVL_W), .ADDR_W(ADDR_W)) i_level (
        .clk(clk), .rst_n(rst_n), .load_top(lvl_load), .inc(lvl_inc), .dec(lvl_dec),
        .level(level), .offset(offset), .at_top(at_top), .at_zero(at_zero));

    ram_probe_stack #(.DATA_W(DATA_W), .SLOTS(SLOTS), .LVL_W(LVL_W)) i_stack (
        .clk(clk), .rst_n(rst_n), .wr_en(save_en), .wr_idx(save_idx), .wr_data(mem_rdata),
        .rd_idx(level), .rd_data(saved_word), .base_data(saved_base));

    // State register and result registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            size_q  <= '0;
            tail_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            if (set_size) begin
                size_q <= size_d;
                tail_q <= tail_d;
            end
        end
    end

    // Transitions
    always_comb begin
        state_d  = state_q;
        lvl_load = 1'b0;
        lvl_inc  = 1'b0;
        lvl_dec  = 1'b0;
        set_size = 1'b0;
        size_d   = size_q;
        tail_d   = tail_q;
        unique case (state_q)
            S_IDLE, S_DONE: if (start) begin
                state_d  = S_SAVE_RD;
                lvl_load = 1'b1;
                set_size = 1'b1;
                size_d   = '0;
                tail_d   = 1'b0;
            end
            S_SAVE_RD:  state_d = S_SAVE_WT;
            S_SAVE_WT:  if (mem_rvalid) state_d = S_SIG_WR;
            S_SIG_WR: begin
                if (at_zero) state_d = S_BSAVE_RD;
                else begin
                    state_d = S_SAVE_RD;
                    lvl_dec = 1'b1;
                end
            end
            S_BSAVE_RD: state_d = S_BSAVE_WT;
            S_BSAVE_WT: if (mem_rvalid) state_d = S_BZERO_WR;
            S_BZERO_WR: state_d = S_BCHK_RD;
            S_BCHK_RD:  state_d = S_BCHK_WT;
            S_BCHK_WT: if (mem_rvalid) begin
                if (mem_rdata != '0) begin
                    state_d  = S_BFIX_WR;
                    set_size = 1'b1;
                    size_d   = '0;
                    tail_d   = 1'b1;
                end else begin
                    state_d = S_CHK_RD;
                end
            end
            S_CHK_RD:   state_d = S_CHK_WT;
            S_CHK_WT: if (mem_rvalid) begin
                if (mem_rdata == signature) begin
                    state_d = S_FIX_WR;
                end else begin
                    state_d  = S_BFIX_WR;
                    set_size = 1'b1;
                    size_d   = SIZE_W'(offset) << BYTE_SH;
                    tail_d   = 1'b1;
                end
            end
            S_FIX_WR: begin
                if (at_top) begin
                    state_d  = S_BFIX_WR;
                    set_size = 1'b1;
                    size_d   = FULL_SIZE;
                    tail_d   = 1'b0;
                end else begin
                    state_d = S_CHK_RD;
                    lvl_inc = 1'b1;
                end
            end
            S_BFIX_WR:  state_d = tail_q ? S_TAIL_WR : S_DONE;
            S_TAIL_WR: begin
                if (at_top) state_d = S_DONE;
                else        lvl_inc = 1'b1;
            end
            default:    state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        mem_req   = 1'b0;
        mem_we    = 1'b0;
        mem_addr  = BASE_ADDR + offset;
        mem_wdata = '0;
        save_en   = 1'b0;
        save_idx  = level;
        unique case (state_q)
            S_SAVE_RD, S_CHK_RD: mem_req = 1'b1;
            S_BSAVE_RD, S_BCHK_RD: begin
                mem_req  = 1'b1;
                mem_addr = BASE_ADDR;
            end
            S_SAVE_WT: save_en = mem_rvalid;
            S_BSAVE_WT: begin
                save_en  = mem_rvalid;
                save_idx = BASE_SLOT;
            end
            S_SIG_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = signature;
            end
            S_BZERO_WR: begin
                mem_req  = 1'b1;
                mem_we   = 1'b1;
                mem_addr = BASE_ADDR;
            end
            S_FIX_WR, S_TAIL_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_wdata = saved_word;
            end
            S_BFIX_WR: begin
                mem_req   = 1'b1;
                mem_we    = 1'b1;
                mem_addr  = BASE_ADDR;
                mem_wdata = saved_base;
            end
            default: ;
        endcase
    end

    assign done       = (state_q == S_DONE);
    assign size_bytes = size_q;

    assert_first_access_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_IDLE || state_q == S_DONE) && start)
        |=> (mem_req && !mem_we && mem_addr == TOP_ADDR));

    assert_zero_then_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_BZERO_WR) |=> (mem_req && !mem_we && mem_addr == BASE_ADDR));

    assert_size_pow2_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $countones(size_bytes) <= 1);

    assert_one_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_we) |=> !mem_req);

    assert_quiet_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !mem_req);

    assert_size_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(done)) |-> $stable(size_bytes));
endmodule

// File: tb/test_ram_size_probe.sv
module test_ram_size_probe;
    localparam int DW = 32;
    localparam int AW = 8;
    localparam int MW = 64;
    localparam int LV = 6;
    localparam int SW = $clog2(MW * 4) + 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic mem_req, mem_we, mem_rvalid, done;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata, mem_rdata;
    logic [SW-1:0] size_bytes;

    always #5 clk = ~clk;

    ram_size_probe #(.DATA_W(DW), .ADDR_W(AW), .MAX_WORDS(MW), .BASE_WORD(0)) i_ram_size_probe (
        .clk(clk), .rst_n(rst_n), .start(start),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .size_bytes(size_bytes));

    int n_chk = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] initv(input int i, input int sd, input bit st);
        if (st && i == 0) return '1;
        return DW'(sd) ^ (DW'(i) * 32'h0100_0193) ^ 32'h5A5A_0000;
    endfunction

    // Memory model with address aliasing and variable read latency
    logic [DW-1:0] mem [256];
    int  phys_mask = 255;
    bit  stuck = 1'b0;
    int  lat = 1;
    int  init_seed = 0;
    bit  init_req = 1'b0;
    bit  pend = 1'b0;
    int  cd = 0;
    logic [DW-1:0] rbuf = '0;
    int  req_viol = 0;
    bit  tr_we[$];
    logic [AW-1:0] tr_addr[$];
    logic [DW-1:0] tr_data[$];

    initial begin
        mem_rvalid = 1'b0;
        mem_rdata  = '0;
    end

    always @(posedge clk) begin
        mem_rvalid <= 1'b0;
        if (init_req)
            for (int i = 0; i < 256; i++) mem[i] <= initv(i, init_seed, stuck);
        if (pend) begin
            if (cd <= 1) begin
                mem_rvalid <= 1'b1;
                mem_rdata  <= rbuf;
                pend       <= 1'b0;
            end else cd <= cd - 1;
        end
        if (rst_n && mem_req) begin
            tr_we.push_back(mem_we);
            tr_addr.push_back(mem_addr);
            tr_data.push_back(mem_wdata);
            if (mem_we) mem[int'(mem_addr) & phys_mask] <= mem_wdata;
            else begin
                if (pend) req_viol++;
                pend <= 1'b1;
                cd   <= lat;
                rbuf <= (stuck && ((int'(mem_addr) & phys_mask) == 0)) ? '1
                        : mem[int'(mem_addr) & phys_mask];
            end
        end
    end

    // Scoreboard monitor
    int    exp_q[$];
    string tag_q[$];
    logic  done_d = 1'b0;
    int    done_viol = 0;

    always @(negedge clk) begin
        done_d <= done;
        if (rst_n && done && !done_d) begin
            if (exp_q.size() == 0) chk(1'b0, "R4 unexpected done", 1, 0);
            else begin
                int e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk(size_bytes == SW'(e), t, longint'(size_bytes), longint'(e));
            end
        end
        if (rst_n && done && mem_req) done_viol++;
    end

    task automatic run(input int pmask, input bit stk, input int latency, input int seed,
                       input int exp, input string tag);
        int b;
        int errs;
        @(negedge clk);
        phys_mask = pmask;
        stuck     = stk;
        lat       = latency;
        init_seed = seed;
        init_req  = 1'b1;
        @(negedge clk);
        init_req = 1'b0;
        b = tr_addr.size();
        exp_q.push_back(exp);
        tag_q.push_back(tag);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(done == 1'b0, "R8 done drops on start", longint'(done), 0);
        while (!done) @(negedge clk);
        @(negedge clk);
        @(negedge clk);
        chk(size_bytes == SW'(exp), "R8 size held", longint'(size_bytes), longint'(exp));
        errs = 0;
        for (int i = 0; i < 256; i++) if (mem[i] !== initv(i, seed, stk)) errs++;
        chk(errs == 0, "R7 contents restored", errs, 0);
        // R1: first read at top of window, then inverted-offset write
        chk(!tr_we[b] && tr_addr[b] == AW'(MW), "R1 first read", tr_addr[b], MW);
        chk(tr_we[b+1] && tr_data[b+1] == ~DW'(MW), "R1 signature", tr_data[b+1], ~DW'(MW));
        chk(tr_we[b+13] && tr_addr[b+13] == AW'(1), "R1 last signature at offset 1",
            tr_addr[b+13], 1);
        // R2: base read, zero write, base re-read
        chk(!tr_we[b+2*(LV+1)] && tr_addr[b+2*(LV+1)] == 0, "R2 base save read",
            tr_addr[b+2*(LV+1)], 0);
        chk(tr_we[b+2*(LV+1)+1] && tr_data[b+2*(LV+1)+1] == 0, "R2 base zero write",
            tr_data[b+2*(LV+1)+1], 0);
        chk(!tr_we[b+2*(LV+1)+2] && tr_addr[b+2*(LV+1)+2] == 0, "R2 base check read",
            tr_we[b+2*(LV+1)+2], 0);
        if (stk) chk(tr_addr.size() - b == 25, "R3 restore-only tail", tr_addr.size() - b, 25);
    endtask

    initial begin
        fork
            begin
                repeat (3) @(negedge clk);
                chk(done == 1'b0 && mem_req == 1'b0, "R9 reset outputs", {done, mem_req}, 0);
                chk(size_bytes == '0, "R9 reset size", longint'(size_bytes), 0);
                rst_n = 1'b1;
                @(negedge clk);
                chk(done == 1'b0 && mem_req == 1'b0, "R9 idle after reset", {done, mem_req}, 0);
                run(127, 1'b0, 1, 32'h11, 256, "R5 no aliasing");
                run(63,  1'b0, 2, 32'h22, 256, "R5 alias at top offset only");
                run(15,  1'b0, 3, 32'h33, 64,  "R4 sixteen words fitted");
                run(7,   1'b0, 2, 32'h44, 32,  "R4 eight words fitted");
                run(0,   1'b0, 1, 32'h55, 4,   "R4 single word fitted");
                run(127, 1'b1, 2, 32'h66, 0,   "R3 stuck base");
                run(31,  1'b0, 1, 32'h77, 128, "R4 thirty-two words back to back");
                chk(req_viol == 0, "R6 one read outstanding", req_viol, 0);
                chk(done_viol == 0, "R8 no request while done", done_viol, 0);
                chk(exp_q.size() == 0, "R4 every probe reported", exp_q.size(), 0);
            end
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog", 1, 0);
            end
        join_any
        disable fork;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule